// File: doc/BRIEF.md
# ADC Conversion Sequencer with Regular and Priority Groups

This block decides which channel an analog-to-digital converter samples next. Two channel lists are held at its inputs. The regular list has up to 16 entries. The priority list has up to 4 entries and can interrupt the regular list. Each list starts from a software start pulse or from an edge on its own hardware trigger pin, and the edge polarity is selectable. The sequencer sends one conversion at a time to the converter as a request with a channel number. It waits for a one-cycle done pulse, then moves on.

The regular list can run once per start, repeat without a break, or run as a series of short bursts. Each burst resumes at the entry after the previous one. The priority list can run whole or one entry per trigger. It can also be chained to run automatically each time the regular list completes. Per-group pulses mark each finished conversion and each finished list, so downstream logic can collect results and raise interrupts.

Channel fields are 5 bits wide and are meant to hold channel numbers 0 to 18. The sequencer issues the stored value as it is. List lengths and burst length are static while a list runs.

Top module: `adcseq_top`

## Requirements
- R1: After reset `convReq` and all four status pulses are low, and no conversion starts until a start or trigger event arrives.
- R2: With `contMode`=0 and `regDiscEn`=0, a regular start issues entries 0..`regLenM1` of the regular list in order and then stops. `regEoc` pulses once per finished conversion, one cycle after the done cycle, and `regEos` pulses together with the `regEoc` of the last entry.
- R3: With `contMode`=1 (and `regDiscEn`=0), the regular list restarts at entry 0 right after its last entry, with no idle cycle. Clearing `contMode` lets the pass in progress finish and then stops.
- R4: With `regDiscEn`=1, each regular start converts `discLenM1`+1 consecutive entries, or only what is left before the end of the list. The next start resumes at the following entry. After the last entry, the next start begins again at entry 0. `regEos` fires only when the list end is reached.
- R5: A priority start issues entries 0..`injLenM1` of the priority list in order. `injEoc` pulses per conversion, and `injEos` pulses with the `injEoc` of the last entry.
- R6: With `injDiscEn`=1, each priority start converts exactly one priority entry and wraps to entry 0 after the last one.
- R7: A priority event that arrives during a regular conversion waits for that conversion's done. Then the whole priority list runs, and after it the regular list resumes at its next entry.
- R8: With `autoInj`=1, the priority list runs immediately after each completed regular list. Edges on `injTrigIn` are ignored; `injSwStart` still works.
- R9: The trigger polarity fields (`regPol`, `injPol`) use the encoding 2'b00 = hardware trigger off, 2'b01 = rising edge, 2'b10 = falling edge and 2'b11 = both edges.
- R10: `injSeqWr` during a priority conversion drops `convReq` for one cycle and suppresses that conversion's pulses. The priority list then restarts at entry 0. At other times `injSeqWr` only rewinds the priority list to entry 0.
- R11: `convReq` and `convChan` stay constant from the start of a request until its done. A start or trigger for a group whose list is already running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regChList | input | REG_DEPTH*CHW | Regular list, entry k in bits [k*CHW +: CHW] |
| regLenM1 | input | $clog2(REG_DEPTH) | Regular list length minus one |
| injChList | input | INJ_DEPTH*CHW | Priority list, entry k in bits [k*CHW +: CHW] |
| injLenM1 | input | $clog2(INJ_DEPTH) | Priority list length minus one |
| contMode | input | 1 | Repeat the regular list continuously |
| regDiscEn | input | 1 | Regular burst mode (overrides contMode) |
| discLenM1 | input | $clog2(DISC_MAX) | Burst length minus one |
| injDiscEn | input | 1 | One priority entry per start |
| autoInj | input | 1 | Chain the priority list after the regular list |
| regPol | input | 2 | Regular hardware trigger polarity |
| injPol | input | 2 | Priority hardware trigger polarity |
| regTrigIn | input | 1 | Regular hardware trigger |
| injTrigIn | input | 1 | Priority hardware trigger |
| regSwStart | input | 1 | Regular software start pulse |
| injSwStart | input | 1 | Priority software start pulse |
| injSeqWr | input | 1 | Priority list rewritten; abort and rewind |
| convReq | output | 1 | Conversion request to the converter |
| convChan | output | CHW | Channel of the current request |
| convDone | input | 1 | One-cycle completion from the converter |
| regEoc | output | 1 | Regular conversion finished |
| regEos | output | 1 | Regular list finished |
| injEoc | output | 1 | Priority conversion finished |
| injEos | output | 1 | Priority list finished |

## Verification
The bench targets the following corner cases:

- **Burst resume and remainder.** A list of seven entries is split into bursts of three. A design that restarts each burst at entry 0 would repeat channels. A design that fills the last burst to its full length would run past the list end.
- **Preemption.** A priority start is placed in the middle of a regular conversion. A design that breaks into the running conversion would issue the priority channels too early. A design that resumes the regular list at the wrong entry would show up in the merged channel log.
- **Aborted priority conversion.** A rewrite during a priority conversion must restart the list. If the aborted request is counted, an extra `injEoc` appears.
- **Polarity and ignored triggers.** Each polarity code is exercised with a single high-then-low pulse. A rising-edge-only detector would miss the falling and both-edges cases. Priority edges under auto-chaining must produce no conversion.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic {S_IDLE, S_CONV} seqState_t;

  // control -> datapath
  typedef struct packed {
    logic regAdv;   // regular conversion finished: step regular index/burst count
    logic injAdv;   // priority conversion finished: step priority index
    logic injRst;   // priority list rewritten: rewind to entry 0
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic regLast;
    logic injLast;
    logic discLast;
    logic regEvt;
    logic injEvt;
  } seqStatus_t;

  // polarity: bit0 selects rising edges, bit1 selects falling edges
  function automatic logic edgeHit(logic [1:0] pol, logic cur, logic prev);
    return (pol[0] & cur & ~prev) | (pol[1] & ~cur & prev);
  endfunction

endpackage

// File: rtl/adcseq_dp.sv
module adcseq_dp
  import adcseq_pkg::*;
#(
  parameter int REG_DEPTH = 16,
  parameter int INJ_DEPTH = 4,
  parameter int DISC_MAX  = 8,
  parameter int CHW       = 5,
  localparam int RIW = $clog2(REG_DEPTH),
  localparam int IIW = $clog2(INJ_DEPTH),
  localparam int DIW = $clog2(DISC_MAX)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [REG_DEPTH*CHW-1:0] regChList,
  input  logic [RIW-1:0]           regLenM1,
  input  logic [INJ_DEPTH*CHW-1:0] injChList,
  input  logic [IIW-1:0]           injLenM1,
  input  logic                     regDiscEn,
  input  logic [DIW-1:0]           discLenM1,
  input  logic                     autoInj,
  input  logic [1:0]               regPol,
  input  logic [1:0]               injPol,
  input  logic                     regTrigIn,
  input  logic                     injTrigIn,
  input  logic                     regSwStart,
  input  logic                     injSwStart,
  input  logic                     selInj,
  input  seqStrobe_t               strobe,
  output seqStatus_t               status,
  output logic [CHW-1:0]           convChan
);

  logic [CHW-1:0] regCh [REG_DEPTH];
  logic [CHW-1:0] injCh [INJ_DEPTH];

  for (genvar g = 0; g < REG_DEPTH; g++) begin : g_regCh
    assign regCh[g] = regChList[g*CHW +: CHW];
  end
  for (genvar g = 0; g < INJ_DEPTH; g++) begin : g_injCh
    assign injCh[g] = injChList[g*CHW +: CHW];
  end

  logic           regTrigQ, injTrigQ;
  logic [RIW-1:0] regIdx;
  logic [IIW-1:0] injIdx;
  logic [DIW-1:0] discCnt;

  always_comb begin
    status.regLast  = (regIdx == regLenM1);
    status.injLast  = (injIdx == injLenM1);
    status.discLast = (discCnt == discLenM1);
    status.regEvt   = regSwStart | edgeHit(regPol, regTrigIn, regTrigQ);
    status.injEvt   = injSwStart | (~autoInj & edgeHit(injPol, injTrigIn, injTrigQ));
  end

  assign convChan = selInj ? injCh[injIdx] : regCh[regIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regTrigQ <= 1'b0;
      injTrigQ <= 1'b0;
      regIdx   <= '0;
      injIdx   <= '0;
      discCnt  <= '0;
    end else begin
      regTrigQ <= regTrigIn;
      injTrigQ <= injTrigIn;
      if (strobe.regAdv) begin
        regIdx  <= status.regLast ? '0 : regIdx + RIW'(1);
        discCnt <= (!regDiscEn || status.discLast || status.regLast) ? '0 : discCnt + DIW'(1);
      end
      if (strobe.injRst)      injIdx <= '0;
      else if (strobe.injAdv) injIdx <= status.injLast ? '0 : injIdx + IIW'(1);
    end
  end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       contMode,
  input  logic       regDiscEn,
  input  logic       injDiscEn,
  input  logic       autoInj,
  input  logic       injSeqWr,
  input  logic       convDone,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       selInj,
  output logic       convReq,
  output logic       regEoc,
  output logic       regEos,
  output logic       injEoc,
  output logic       injEos
);

  seqState_t state;
  logic regBusy, injBusy, regPend, injPend;

  logic conv, doneR, doneI, abortI, regEnd, regStop, injStop, freeSlot;
  logic regBusyA, injBusyA, regPendA, injPendA;

  always_comb begin
    conv     = (state == S_CONV);
    abortI   = conv & selInj & injSeqWr;
    doneR    = conv & convDone & ~selInj;
    doneI    = conv & convDone & selInj & ~abortI;
    regEnd   = doneR & status.regLast;
    regStop  = doneR & (regDiscEn ? (status.discLast | status.regLast)
                                  : (status.regLast & ~contMode));
    injStop  = doneI & (status.injLast | injDiscEn);
    regBusyA = regBusy & ~regStop;
    injBusyA = injBusy & ~injStop;
    regPendA = regPend | (status.regEvt & ~regBusy);
    injPendA = injPend | (status.injEvt & ~injBusy) | (regEnd & autoInj);
    freeSlot = ~conv | doneR | doneI;
    strobe.regAdv = doneR;
    strobe.injAdv = doneI;
    strobe.injRst = injSeqWr;
  end

  assign convReq = conv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      selInj  <= 1'b0;
      regBusy <= 1'b0;
      injBusy <= 1'b0;
      regPend <= 1'b0;
      injPend <= 1'b0;
      regEoc  <= 1'b0;
      regEos  <= 1'b0;
      injEoc  <= 1'b0;
      injEos  <= 1'b0;
    end else begin
      regEoc  <= doneR;
      regEos  <= regEnd;
      injEoc  <= doneI;
      injEos  <= doneI & status.injLast;
      regBusy <= regBusyA;
      injBusy <= injBusyA;
      regPend <= regPendA;
      injPend <= injPendA;
      if (abortI) begin
        state   <= S_IDLE;
        injBusy <= 1'b0;
        injPend <= 1'b1;
      end else if (freeSlot) begin
        if (injBusyA) begin
          state  <= S_CONV;
          selInj <= 1'b1;
        end else if (injPendA) begin
          state   <= S_CONV;
          selInj  <= 1'b1;
          injBusy <= 1'b1;
          injPend <= 1'b0;
        end else if (regBusyA) begin
          state  <= S_CONV;
          selInj <= 1'b0;
        end else if (regPendA) begin
          state   <= S_CONV;
          selInj  <= 1'b0;
          regBusy <= 1'b1;
          regPend <= 1'b0;
        end else begin
          state <= S_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int REG_DEPTH = 16,
  parameter int INJ_DEPTH = 4,
  parameter int DISC_MAX  = 8,
  parameter int CHW       = 5,
  localparam int RIW = $clog2(REG_DEPTH),
  localparam int IIW = $clog2(INJ_DEPTH),
  localparam int DIW = $clog2(DISC_MAX)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [REG_DEPTH*CHW-1:0] regChList,
  input  logic [RIW-1:0]           regLenM1,
  input  logic [INJ_DEPTH*CHW-1:0] injChList,
  input  logic [IIW-1:0]           injLenM1,
  input  logic                     contMode,
  input  logic                     regDiscEn,
  input  logic [DIW-1:0]           discLenM1,
  input  logic                     injDiscEn,
  input  logic                     autoInj,
  input  logic [1:0]               regPol,
  input  logic [1:0]               injPol,
  input  logic                     regTrigIn,
  input  logic                     injTrigIn,
  input  logic                     regSwStart,
  input  logic                     injSwStart,
  input  logic                     injSeqWr,
  output logic                     convReq,
  output logic [CHW-1:0]           convChan,
  input  logic                     convDone,
  output logic                     regEoc,
  output logic                     regEos,
  output logic                     injEoc,
  output logic                     injEos
);

  seqStrobe_t strobe;
  seqStatus_t status;
  logic       selInj;

  adcseq_ctrl i_ctrl (
    .clk, .rstN, .contMode, .regDiscEn, .injDiscEn, .autoInj, .injSeqWr, .convDone,
    .status, .strobe, .selInj, .convReq, .regEoc, .regEos, .injEoc, .injEos
  );

  adcseq_dp #(
    .REG_DEPTH(REG_DEPTH), .INJ_DEPTH(INJ_DEPTH), .DISC_MAX(DISC_MAX), .CHW(CHW)
  ) i_dp (
    .clk, .rstN, .regChList, .regLenM1, .injChList, .injLenM1, .regDiscEn, .discLenM1,
    .autoInj, .regPol, .injPol, .regTrigIn, .injTrigIn, .regSwStart, .injSwStart,
    .selInj, .strobe, .status, .convChan
  );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rstN,
  input logic           convReq,
  input logic [CHW-1:0] convChan,
  input logic           convDone,
  input logic           injSeqWr,
  input logic           regEoc,
  input logic           regEos,
  input logic           injEoc,
  input logic           injEos
);

  p_req_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone && !injSeqWr |=> convReq && $stable(convChan));

  p_reg_eos_with_eoc_r2: assert property (@(posedge clk) disable iff (!rstN)
    regEos |-> regEoc);

  p_inj_eos_with_eoc_r5: assert property (@(posedge clk) disable iff (!rstN)
    injEos |-> injEoc);

  p_eoc_after_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regEoc || injEoc) |-> $past(convReq && convDone));

  p_one_group_per_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(regEoc && injEoc));

endmodule

bind adcseq_top adcseq_chk #(.CHW(CHW)) i_chk (
  .clk(clk), .rstN(rstN), .convReq(convReq), .convChan(convChan), .convDone(convDone),
  .injSeqWr(injSeqWr), .regEoc(regEoc), .regEos(regEos), .injEoc(injEoc), .injEos(injEos)
);

// File: tb/test_adcseq_top.sv
module test_adcseq_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic [79:0] regChList;
  logic [19:0] injChList;
  logic [3:0]  regLenM1 = '0;
  logic [1:0]  injLenM1 = '0;
  logic [2:0]  discLenM1 = '0;
  logic contMode = 0, regDiscEn = 0, injDiscEn = 0, autoInj = 0;
  logic [1:0] regPol = 0, injPol = 0;
  logic regTrigIn = 0, injTrigIn = 0, regSwStart = 0, injSwStart = 0, injSeqWr = 0;
  logic convDone = 0;
  logic convReq, regEoc, regEos, injEoc, injEos;
  logic [4:0] convChan;

  int regCh [16];
  int injCh [4];
  always_comb begin
    for (int k = 0; k < 16; k++) regChList[k*5 +: 5] = 5'(regCh[k]);
    for (int k = 0; k < 4; k++)  injChList[k*5 +: 5] = 5'(injCh[k]);
  end

  adcseq_top i_adcseq_top (.*);

  int vecs = 0, fails = 0, cyc = 0;
  int lat = 2, cnt = 0;
  int logQ[$];
  int expQ[$];
  int nREoc = 0, nREos = 0, nIEoc = 0, nIEos = 0;

  // ---------------- behavioural reference model ----------------
  bit mConv, mOnInj, mRRun, mIRun, mRWait, mIWait, mPrevR, mPrevI;
  bit mREoc, mREos, mIEoc, mIEos;
  int mR, mI, mB;
  bit evR, evI, dR, dI, ab, rL, iL, bL, rEnd, rb, ib, rp, ip, fr;

  function automatic bit sees(logic [1:0] pol, bit now, bit was);
    case (pol)
      2'b01:   return now && !was;
      2'b10:   return !now && was;
      2'b11:   return now != was;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mConv = 0; mOnInj = 0; mRRun = 0; mIRun = 0; mRWait = 0; mIWait = 0;
      mPrevR = 0; mPrevI = 0; mR = 0; mI = 0; mB = 0;
      mREoc = 0; mREos = 0; mIEoc = 0; mIEos = 0;
    end else begin
      evR = regSwStart || sees(regPol, regTrigIn, mPrevR);
      evI = injSwStart || (!autoInj && sees(injPol, injTrigIn, mPrevI));
      mPrevR = regTrigIn; mPrevI = injTrigIn;
      ab = mConv && mOnInj && injSeqWr;
      dR = mConv && convDone && !mOnInj;
      dI = mConv && convDone && mOnInj && !ab;
      rL = (mR == int'(regLenM1)); iL = (mI == int'(injLenM1)); bL = (mB == int'(discLenM1));
      rEnd = dR && rL;
      mREoc = dR; mREos = rEnd; mIEoc = dI; mIEos = dI && iL;
      rb = mRRun && !(dR && (regDiscEn ? (bL || rL) : (rL && !contMode)));
      ib = mIRun && !(dI && (iL || injDiscEn));
      ip = mIWait || (evI && !mIRun) || (rEnd && autoInj);
      rp = mRWait || (evR && !mRRun);
      if (dR) begin
        mB = (!regDiscEn || bL || rL) ? 0 : mB + 1;
        mR = rL ? 0 : mR + 1;
      end
      if (injSeqWr) mI = 0;
      else if (dI) mI = iL ? 0 : mI + 1;
      fr = !mConv || dR || dI;
      mRRun = rb; mIRun = ib; mRWait = rp; mIWait = ip;
      if (ab) begin
        mConv = 0; mIRun = 0; mIWait = 1;
      end else if (fr) begin
        if (ib) begin mConv = 1; mOnInj = 1; end
        else if (ip) begin mConv = 1; mOnInj = 1; mIRun = 1; mIWait = 0; end
        else if (rb) begin mConv = 1; mOnInj = 0; end
        else if (rp) begin mConv = 1; mOnInj = 0; mRRun = 1; mRWait = 0; end
        else mConv = 0;
      end
    end
  end

  // ---------------- monitor, converter model, per-clock compare ----------------
  always @(negedge clk) begin
    if (rstN) begin
      vecs++;
      if (convReq !== mConv || (mConv && int'(convChan) != (mOnInj ? injCh[mI] : regCh[mR]))) begin
        fails++;
        $display("FAIL R11 cycle %0d: req/chan actual %0d/%0d expected %0d/%0d", cyc,
                 convReq, convChan, mConv, mOnInj ? injCh[mI] : regCh[mR]);
      end
      if ({regEoc, regEos, injEoc, injEos} !== {mREoc, mREos, mIEoc, mIEos}) begin
        fails++;
        $display("FAIL R2 cycle %0d: pulses actual %b expected %b", cyc,
                 {regEoc, regEos, injEoc, injEos}, {mREoc, mREos, mIEoc, mIEos});
      end
      nREoc += int'(regEoc); nREos += int'(regEos);
      nIEoc += int'(injEoc); nIEos += int'(injEos);
    end
    convDone = 0;
    if (rstN && convReq) begin
      cnt++;
      if (cnt >= lat) begin
        convDone = 1; cnt = 0;
        logQ.push_back(int'(convChan));
      end
    end else cnt = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(string r, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic chkLog(string r);
    chk(r, "log length", logQ.size(), expQ.size());
    for (int k = 0; k < expQ.size() && k < logQ.size(); k++)
      chk(r, "logged channel", logQ[k], expQ[k]);
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 4) begin
      tick();
      quiet = convReq ? 0 : quiet + 1;
    end
  endtask

  task automatic doReset();
    rstN = 0; contMode = 0; regDiscEn = 0; injDiscEn = 0; autoInj = 0;
    regPol = 0; injPol = 0; regTrigIn = 0; injTrigIn = 0; regSwStart = 0; injSwStart = 0;
    injSeqWr = 0; regLenM1 = 0; injLenM1 = 0; discLenM1 = 0; lat = 2;
    tick(3);
    rstN = 1;
    tick();
    logQ.delete(); expQ.delete();
    nREoc = 0; nREos = 0; nIEoc = 0; nIEos = 0;
  endtask

  task automatic pulseReg(); regSwStart = 1; tick(); regSwStart = 0; endtask
  task automatic pulseInj(); injSwStart = 1; tick(); injSwStart = 0; endtask

  initial begin
    for (int k = 0; k < 16; k++) regCh[k] = k;
    injCh[0] = 18; injCh[1] = 16; injCh[2] = 17; injCh[3] = 12;

    // R1: reset state and no spontaneous activity
    doReset();
    tick(5);
    chk("R1", "convReq idle", int'(convReq), 0);
    chk("R1", "pulses idle", int'({regEoc, regEos, injEoc, injEos}), 0);
    chk("R1", "no conversions", logQ.size(), 0);

    // R2: single regular pass of five entries
    doReset(); regLenM1 = 4; lat = 2;
    pulseReg(); waitIdle();
    for (int k = 0; k < 5; k++) expQ.push_back(k);
    chkLog("R2");
    chk("R2", "regEoc count", nREoc, 5);
    chk("R2", "regEos count", nREos, 1);

    // R3: continuous mode, stop after current pass
    doReset(); regLenM1 = 2; lat = 1; contMode = 1;
    pulseReg();
    while (logQ.size() < 7) tick();
    contMode = 0;
    waitIdle();
    for (int k = 0; k < 9; k++) expQ.push_back(k % 3);
    chkLog("R3");
    chk("R3", "regEos count", nREos, 3);

    // R4: bursts of three over a seven-entry list
    doReset(); regLenM1 = 6; discLenM1 = 2; regDiscEn = 1; lat = 2;
    pulseReg(); waitIdle();
    chk("R4", "burst 1 length", logQ.size(), 3);
    chk("R4", "no eos after burst 1", nREos, 0);
    pulseReg(); waitIdle();
    pulseReg(); waitIdle();
    chk("R4", "eos at list end", nREos, 1);
    pulseReg(); waitIdle();
    expQ = '{0, 1, 2, 3, 4, 5, 6, 0, 1, 2};
    chkLog("R4");

    // R5: whole priority list
    doReset(); injLenM1 = 2; lat = 3;
    pulseInj(); waitIdle();
    expQ = '{18, 16, 17};
    chkLog("R5");
    chk("R5", "injEoc count", nIEoc, 3);
    chk("R5", "injEos count", nIEos, 1);

    // R6: one priority entry per start, wrapping
    doReset(); injLenM1 = 1; injDiscEn = 1;
    pulseInj(); waitIdle();
    chk("R6", "eos not yet", nIEos, 0);
    pulseInj(); waitIdle();
    pulseInj(); waitIdle();
    expQ = '{18, 16, 18};
    chkLog("R6");
    chk("R6", "injEos count", nIEos, 1);

    // R7: priority start during the second regular conversion
    doReset(); regLenM1 = 5; injLenM1 = 2; lat = 3;
    pulseReg();
    while (nREoc < 1) tick();
    pulseInj();
    waitIdle();
    expQ = '{0, 1, 18, 16, 17, 2, 3, 4, 5};
    chkLog("R7");
    chk("R7", "regEos count", nREos, 1);

    // R8: auto chaining, priority hardware edges ignored
    doReset(); autoInj = 1; injPol = 2'b11; regLenM1 = 1; injLenM1 = 2;
    injTrigIn = 1; tick(3); injTrigIn = 0; tick(6);
    chk("R8", "priority edge ignored", logQ.size(), 0);
    pulseReg(); waitIdle();
    expQ = '{0, 1, 18, 16, 17};
    chkLog("R8");
    chk("R8", "injEos count", nIEos, 1);

    // R9: polarity encodings on both trigger inputs
    for (int p = 0; p < 4; p++) begin
      doReset(); regPol = 2'(p);
      tick(); regTrigIn = 1; waitIdle(); regTrigIn = 0; waitIdle();
      chk("R9", $sformatf("regular hits pol %0d", p), logQ.size(), (p == 0) ? 0 : (p == 3) ? 2 : 1);
      doReset(); injPol = 2'(p);
      tick(); injTrigIn = 1; waitIdle(); injTrigIn = 0; waitIdle();
      chk("R9", $sformatf("priority hits pol %0d", p), logQ.size(), (p == 0) ? 0 : (p == 3) ? 2 : 1);
    end

    // R10: rewrite during a priority conversion
    doReset(); injLenM1 = 3; lat = 4;
    pulseInj();
    while (nIEoc < 1) tick();
    injSeqWr = 1; tick(); injSeqWr = 0;
    waitIdle();
    expQ = '{18, 18, 16, 17, 12};
    chkLog("R10");
    chk("R10", "injEoc count", nIEoc, 5);
    chk("R10", "injEos count", nIEos, 1);

    // R11: extra start while the regular list is running
    doReset(); regLenM1 = 3; lat = 3;
    pulseReg(); tick(2); pulseReg();
    waitIdle(); tick(5);
    expQ = '{0, 1, 2, 3};
    chkLog("R11");
    chk("R11", "regEos count", nREos, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule